// File: doc/BRIEF.md
# Jump-Capable Galois Shift Register

This block is an 80-stage linear feedback shift register in Galois form that advances by one step in each cycle where its step enable is high. Each step shifts the state toward the high end of the register. The feedback bit is the top stage XORed with a serial input bit. It is folded into a fixed set of tap stages. Viewed as a polynomial over GF(2), a plain step multiplies the state by x modulo the tap polynomial.

A jump-control bit is sampled on every step. When it is set, each stage also XORs its own value from before the step into its new value. That multiplies the state by x+1 rather than x. For the chosen polynomial, this equals advancing the register 2^40−23 plain steps in a single cycle. A surrounding generator chooses the control bit and serial input on each cycle and reads the whole 80-bit state.

Top module: `jlfsr_jump_reg`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, all 80 bits of `state` become 0 after that edge.
- R2: When `clr` is high at a rising edge, `state` becomes all zeros after that edge, even if `step_en` is also high.
- R3: When `step_en` and `clr` are both low, `state` keeps its value, whatever `din` and `jump` are doing.
- R4: A plain step (`step_en`=1, `clr`=0, `jump`=0) gives new bit i = old bit i−1 for i in 1..79 and new bit 0 = 0. Each stage whose index is in the tap set is then XORed with the feedback bit f = old bit 79 XOR `din`. The tap set is {0,2,4,6,7,8,9,13,14,16,17,20,22,24,26,27,28,34,35,37,39,41,43,49,51,52,54,56,62,67,69,71,73,76,78,79}.
- R5: The serial input is part of the feedback. From the all-zero state, one plain step with `din`=1 leaves exactly the tap-set stages at 1.
- R6: A jump step (`jump`=1) gives exactly the plain-step result of R4 XORed, bit for bit, with the state before the step. This is multiplication by x+1.
- R7: From the all-zero state, a jump step with `din`=1 gives the same result as the plain step of R5, because the XORed old value is zero.
- R8: Stages outside the tap set never take the feedback bit. From a state with only stage 79 set, a plain step with `din`=0 drops that bit off the top and leaves exactly the tap-set stages at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear; takes priority over stepping |
| step_en | input | 1 | Advances the register by one step when high |
| din | input | 1 | Serial input bit folded into the feedback |
| jump | input | 1 | 1 selects a jump step (x+1), 0 a plain step (x) |
| state | output | 80 | Full register contents, bit i is stage i |

## Verification
The register is driven through long walks of pseudo-random `din` values with the control bit held at 0, and then with `jump` mixed in. The first walk separates a wrong shift direction or wrong tap positions from a correct plain step. The second shows whether the old-value XOR is applied only on jump steps. Each jump step is also compared with a reduced model: the plain-step result XORed with the old state. Single steps from the all-zero state with `din`=1 expose the tap mask directly and show whether the serial input reaches the feedback. A step from a state holding only stage 79 shows whether the top bit drops off correctly. Idle cycles with toggling inputs, and a clear raised together with the enable, confirm hold and priority.

// File: rtl/jlfsr_pkg.sv
`timescale 1ns/1ps
// Package jlfsr_pkg
// Shared constants and types for the jump-capable shift register.
// Assumes the default register is 80 stages with the fixed tap mask below.
package jlfsr_pkg;
    localparam int unsigned JL_WIDTH = 80;
    // Bit i set means stage i takes the feedback bit.
    localparam logic [JL_WIDTH-1:0] JL_TAPS_DEFAULT = 80'hD2A8_415A_0AAC_1D53_63D5;

    // Kind of step applied in a cycle.
    typedef enum logic [1:0] {
        JL_OP_HOLD  = 2'd0,
        JL_OP_PLAIN = 2'd1,
        JL_OP_JUMP  = 2'd2,
        JL_OP_CLEAR = 2'd3
    } jl_op_e;
endpackage

// File: rtl/jlfsr_shift_core.sv
`timescale 1ns/1ps
// Module jlfsr_shift_core
// Combinational plain step: shifts the state up one stage, puts 0 into
// stage 0, and XORs the feedback (top stage ^ serial input) into each tap.
// Assumes TAPS is a constant mask with one bit per stage.
module jlfsr_shift_core #(
    parameter int unsigned W = 80,
    parameter logic [W-1:0] TAPS = '0
) (
    input  logic [W-1:0] cur_i,
    input  logic         din_i,
    output logic [W-1:0] nxt_o
);
    logic fb;

    // Feedback bit taken from the top stage and the serial input.
    always_comb fb = cur_i[W-1] ^ din_i;

    // One stage per index; the tap mask picks which stages take feedback.
    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == 0) begin : g_low
            if (TAPS[i]) begin : g_tap
                assign nxt_o[i] = fb;
            end else begin : g_plain
                assign nxt_o[i] = 1'b0;
            end
        end else begin : g_up
            if (TAPS[i]) begin : g_tap
                assign nxt_o[i] = cur_i[i-1] ^ fb;
            end else begin : g_plain
                assign nxt_o[i] = cur_i[i-1];
            end
        end
    end
endmodule

// File: rtl/jlfsr_jump_mix.sv
`timescale 1ns/1ps
// Module jlfsr_jump_mix
// Turns the plain-step result into the jump-step result when jump_i is set
// by XORing each stage's pre-step value into it (multiplication by x+1).
// Assumes shifted_i is the plain step of cur_i.
module jlfsr_jump_mix #(
    parameter int unsigned W = 80
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] shifted_i,
    input  logic         jump_i,
    output logic [W-1:0] mixed_o
);
    // Per-stage gated XOR of the old value.
    for (genvar i = 0; i < W; i++) begin : g_mix
        assign mixed_o[i] = shifted_i[i] ^ (jump_i & cur_i[i]);
    end
endmodule

// File: rtl/jlfsr_state_reg.sv
`timescale 1ns/1ps
// Module jlfsr_state_reg
// State flops with synchronous active-low reset, synchronous clear that
// overrides the enable, and a load enable. Holds when neither is active.
module jlfsr_state_reg #(
    parameter int unsigned W = 80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  jlfsr_pkg::jl_op_e op_i,
    input  logic [W-1:0] nxt_i,
    output logic [W-1:0] q_o
);
    import jlfsr_pkg::*;

    // Register update chosen by the decoded operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            case (op_i)
                JL_OP_CLEAR: q_o <= '0;
                JL_OP_PLAIN,
                JL_OP_JUMP:  q_o <= nxt_i;
                default:     q_o <= q_o;
            endcase
        end
    end
endmodule

// File: rtl/jlfsr_jump_reg.sv
`timescale 1ns/1ps
// Module jlfsr_jump_reg
// Top of the 80-stage Galois shift register with a per-step jump control.
// Plain step = multiply by x, jump step = multiply by x+1 modulo the tap
// polynomial. Clear beats step enable; idle cycles hold the state.
module jlfsr_jump_reg #(
    parameter int unsigned W = jlfsr_pkg::JL_WIDTH,
    parameter logic [W-1:0] TAPS = jlfsr_pkg::JL_TAPS_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step_en,
    input  logic         din,
    input  logic         jump,
    output logic [W-1:0] state
);
    import jlfsr_pkg::*;

    jl_op_e       op;
    logic [W-1:0] shifted;
    logic [W-1:0] mixed;

    // Decode control inputs with clear first, then step kind.
    always_comb begin
        if (clr)          op = JL_OP_CLEAR;
        else if (!step_en) op = JL_OP_HOLD;
        else if (jump)    op = JL_OP_JUMP;
        else              op = JL_OP_PLAIN;
    end

    jlfsr_shift_core #(.W(W), .TAPS(TAPS)) shift_i (
        .cur_i (state),
        .din_i (din),
        .nxt_o (shifted)
    );

    jlfsr_jump_mix #(.W(W)) mix_i (
        .cur_i     (state),
        .shifted_i (shifted),
        .jump_i    (jump),
        .mixed_o   (mixed)
    );

    jlfsr_state_reg #(.W(W)) reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (op),
        .nxt_i (mixed),
        .q_o   (state)
    );
endmodule

// File: rtl/jlfsr_jump_reg_chk.sv
`timescale 1ns/1ps
// Module jlfsr_jump_reg_chk
// Assertion checker bound to jlfsr_jump_reg; observes ports only.
module jlfsr_jump_reg_chk #(
    parameter int unsigned W = 80,
    parameter logic [W-1:0] TAPS = '0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         step_en,
    input logic         din,
    input logic         jump,
    input logic [W-1:0] state
);
    // Reference plain step used to judge the next-cycle state.
    function automatic logic [W-1:0] ref_plain(input logic [W-1:0] c, input logic d);
        logic f;
        f = c[W-1] ^ d;
        return {c[W-2:0], 1'b0} ^ (f ? TAPS : '0);
    endfunction

    logic rst_seen;

    // Remembers that reset was sampled low at the previous edge.
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // After a reset edge the state must read all zeros.
    always_ff @(posedge clk) begin
        if (rst_seen) begin
            assert_reset_zero_R1: assert (state == '0);
        end
    end

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> state == '0);

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step_en) |=> $stable(state));

    assert_plain_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step_en && !jump) |=> state == ref_plain($past(state), $past(din)));

    assert_stage0_feedback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step_en && !jump) |=> state[0] == ($past(state[W-1]) ^ $past(din)));

    assert_jump_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step_en && jump) |=> state == (ref_plain($past(state), $past(din)) ^ $past(state)));
endmodule

bind jlfsr_jump_reg jlfsr_jump_reg_chk #(.W(W), .TAPS(TAPS)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .step_en (step_en),
    .din     (din),
    .jump    (jump),
    .state   (state)
);

// File: tb/jlfsr_jump_reg_tb_top.sv
`timescale 1ns/1ps
// Directed bench for jlfsr_jump_reg: one task per scenario, own model.
module jlfsr_jump_reg_tb_top;
    localparam int W = 80;

    logic         clk = 1'b0;
    logic         rst_n, clr, step_en, din, jump;
    logic [W-1:0] state;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] seed = 32'h1234_5678;
    logic [W-1:0] tap_mask;
    logic [W-1:0] model;

    int tap_list [36] = '{0,2,4,6,7,8,9,13,14,16,17,20,22,24,26,27,28,34,35,
                          37,39,41,43,49,51,52,54,56,62,67,69,71,73,76,78,79};

    always #2 clk = ~clk;   // 4 ns period

    jlfsr_jump_reg dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step_en(step_en),
        .din(din), .jump(jump), .state(state)
    );

    function automatic logic [W-1:0] m_step(input logic [W-1:0] s, input logic d,
                                            input logic j, input logic [W-1:0] tm);
        logic [W-1:0] n;
        logic f;
        f = s[W-1] ^ d;
        for (int i = 0; i < W; i++) begin
            n[i] = ((i == 0) ? 1'b0 : s[i-1]) ^ (tm[i] & f);
        end
        if (j) n = n ^ s;
        return n;
    endfunction

    function automatic logic [W-1:0] m_plain_then_x1(input logic [W-1:0] s, input logic d,
                                                     input logic [W-1:0] tm);
        return m_step(s, d, 1'b0, tm) ^ s;
    endfunction

    task automatic check_vec(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[16];
    endfunction

    // Drive one cycle at the falling edge, then wait past the rising edge.
    task automatic cycle(input logic r, input logic c, input logic e, input logic d, input logic j);
        @(negedge clk);
        rst_n = r; clr = c; step_en = e; din = d; jump = j;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        model = '0;
        check_vec("R1 reset state", state, '0);
    endtask

    task automatic t_inject();
        cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        model = m_step(model, 1'b1, 1'b0, tap_mask);
        check_vec("R5 din folded into feedback", state, tap_mask);
    endtask

    task automatic t_plain_walk(input int n);
        for (int k = 0; k < n; k++) begin
            logic d;
            d = next_rand();
            cycle(1'b1, 1'b0, 1'b1, d, 1'b0);
            model = m_step(model, d, 1'b0, tap_mask);
            check_vec("R4 plain step", state, model);
        end
    endtask

    task automatic t_jump_walk(input int n);
        for (int k = 0; k < n; k++) begin
            logic d, j;
            logic [W-1:0] old;
            d = next_rand();
            j = next_rand();
            old = model;
            cycle(1'b1, 1'b0, 1'b1, d, j);
            model = m_step(model, d, j, tap_mask);
            if (j) check_vec("R6 jump equals x*s^s", state, m_plain_then_x1(old, d, tap_mask));
            else   check_vec("R4 plain step in mix", state, model);
        end
    endtask

    task automatic t_hold();
        for (int k = 0; k < 6; k++) begin
            cycle(1'b1, 1'b0, 1'b0, k[0], k[1]);
            check_vec("R3 idle hold", state, model);
        end
    endtask

    task automatic t_clear();
        cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        model = '0;
        check_vec("R2 clear beats enable", state, '0);
    endtask

    task automatic t_jump_from_zero();
        cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        model = tap_mask;
        check_vec("R7 jump from zero", state, tap_mask);
    endtask

    // Build state with only stage 79 set: inject 1 from zero, then 79 steps with
    // din chosen to cancel feedback, tracked by the model.
    task automatic t_top_bit();
        cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        model = '0;
        // Shift a single 1 into stage 0 via feedback needs tap 0; then move it up.
        cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        model = m_step(model, 1'b1, 1'b0, tap_mask);
        for (int k = 0; k < W; k++) begin
            logic d;
            d = model[W-1];   // cancels feedback so taps are untouched
            cycle(1'b1, 1'b0, 1'b1, d, 1'b0);
            model = m_step(model, d, 1'b0, tap_mask);
            if (model == {1'b1, {(W-1){1'b0}}}) break;
        end
        check_vec("R8 top-only state reached", state, {1'b1, {(W-1){1'b0}}});
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        model = tap_mask;
        check_vec("R8 top bit drops, taps only", state, tap_mask);
    endtask

    task automatic t_reset_mid();
        cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        model = '0;
        check_vec("R1 reset during stepping", state, '0);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tap_mask = '0;
        foreach (tap_list[i]) tap_mask[tap_list[i]] = 1'b1;
        rst_n = 1'b0; clr = 1'b0; step_en = 1'b0; din = 1'b0; jump = 1'b0;
        model = '0;
        t_reset();
        t_inject();
        t_plain_walk(60);
        t_hold();
        t_jump_walk(120);
        t_hold();
        t_clear();
        t_jump_from_zero();
        t_jump_walk(40);
        t_top_bit();
        t_jump_walk(20);
        t_reset_mid();
        finish_run();
    end
endmodule